// File: doc/BRIEF.md
# Video Byte-Pair Fetch Sequencer

This block times the video memory traffic of a raster display in which every group of eight pixels is described by one bitmap byte and one colour attribute byte. A 4-bit horizontal sub-counter, advanced once per pixel clock enable, splits each 16-count window into eight CPU-clock slots. In the first four slots the block issues four memory reads in a burst. The reads fetch two complete byte pairs, and in each pair the bitmap byte comes before the attribute byte. The second half of the window carries no video reads, so the CPU has the memory to itself there.

Each pair goes to the output stage on a single clock enable. The bitmap byte loads into an 8-bit pixel shift register and the attribute byte into an attribute output register on the same edge. The second pair waits in staging registers until the first pair has finished shifting out. The block also drives an address-increment strobe for the external address counter, a CPU contention flag, and a copy of the display-active input delayed so that it lines up with the serialized pixels. The memory array, the address counter, colour decoding and sync generation are outside the block.

Top module: `pair_fetch_seq`

## Requirements
- R1: While reset is applied, and until the first enabled clock after reset, `pix_out`, `attr_out` and `vid_en_out` are 0.
- R2: `mem_req` is high exactly when `pix_ce` and `disp_active` are high, `hcount[3]` is 0 and `hcount[0]` is 1. These are counts 1, 3, 5 and 7, so there are four reads per window.
- R3: `mem_attr_sel` equals `hcount[1]`. A read at count 1 or 5 fetches a bitmap byte (select 0), and a read at count 3 or 7 fetches an attribute byte (select 1).
- R4: `shift_load` is high exactly when `pix_ce` is high and `hcount` is 3 or 11, so it lasts one enabled pixel clock per pair.
- R5: On a load at count 3, the shift register takes the bitmap byte read at count 1 and `attr_out` takes the attribute byte read at count 3, both on the same edge.
- R6: On a load at count 11, the shift register takes the bitmap byte read at count 5 and `attr_out` takes the attribute byte read at count 7. These bytes were held through the intervening shifting, and `mem_rdata` is ignored in every cycle without a read.
- R7: `addr_inc` is high only together with `shift_load`, and only when the pair being loaded was fetched.
- R8: `pix_out` is bit 7 of the shift register. On every enabled clock without a load, the register shifts one place toward the MSB and fills with 0. Without `pix_ce` it holds.
- R9: `cpu_contend` is high exactly when `disp_active` is high and `hcount` is 0 to 7. It is never high at counts 8 to 15.
- R10: `vid_en_out` equals `disp_active` as sampled four enabled pixel clocks earlier.
- R11: A load whose pair was not fetched because the display was inactive puts 0 into both the shift register and `attr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel clock enable |
| hcount | input | 4 | Horizontal sub-counter |
| disp_active | input | 1 | Display area active |
| mem_rdata | input | 8 | Read data from video memory, valid during `mem_req` |
| mem_req | output | 1 | Video memory read request |
| mem_attr_sel | output | 1 | 0 selects the bitmap byte, 1 the attribute byte |
| addr_inc | output | 1 | Advance the external display address |
| shift_load | output | 1 | Parallel load of the output stage |
| cpu_contend | output | 1 | CPU must wait for memory |
| pix_out | output | 1 | Serialized pixel bit |
| attr_out | output | 8 | Attribute for the pixels being shifted |
| vid_en_out | output | 1 | Delayed display-active |

## Verification
The bench stalls `pix_ce` at random, including on load counts. A design that keyed its strobes on the count alone would then reload the shifter twice and corrupt the pixel stream. It places a fresh random byte on `mem_rdata` in every cycle, so a design that captured the bus outside its read slots, or that overwrote the waiting second pair, would show wrong pixels after count 11. It also switches the display on and off in mid-window, which exposes pairs that were never fetched but still reach the output, address strobes issued for empty pairs, and a video-enable delay of the wrong length.

// File: rtl/pair_fetch_pkg.sv
package pair_fetch_pkg;
  parameter int unsigned PIX_W   = 8;
  parameter int unsigned HC_W    = 4;
  parameter int unsigned VID_DLY = 4;

  localparam logic [HC_W-1:0] LOAD_FIRST  = HC_W'(3);
  localparam logic [HC_W-1:0] LOAD_SECOND = HC_W'(11);

  typedef logic [PIX_W-1:0] pix_byte_t;

  typedef struct packed {
    pix_byte_t bmp;
    pix_byte_t attr;
    logic      valid;
  } pair_t;
endpackage

// File: rtl/pfs_rst_sync.sv
module pfs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pfs_decode.sv
module pfs_decode
  import pair_fetch_pkg::*;
(
  input  logic [HC_W-1:0] hcount,
  input  logic            pix_ce,
  input  logic            disp_active,
  output logic            req,
  output logic            attr_sel,
  output logic            bank_b,
  output logic            load,
  output logic            load_second,
  output logic            contend
);
  logic in_burst;

  always_comb begin
    in_burst    = ~hcount[HC_W-1];
    req         = pix_ce & disp_active & in_burst & hcount[0];
    attr_sel    = hcount[1];
    bank_b      = hcount[2];
    load        = pix_ce & (hcount == LOAD_FIRST || hcount == LOAD_SECOND);
    load_second = hcount[HC_W-1];
    contend     = disp_active & in_burst;
  end
endmodule

// File: rtl/pfs_pair_stage.sv
module pfs_pair_stage
  import pair_fetch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req,
  input  logic      attr_sel,
  input  logic      bank_b,
  input  logic      load,
  input  logic      load_second,
  input  pix_byte_t rdata,
  output pair_t     out_pair
);
  pix_byte_t bmp_a_q, bmp_a_d;
  pix_byte_t bmp_b_q, bmp_b_d;
  pix_byte_t attr_b_q, attr_b_d;
  logic      vld_b_q, vld_b_d;

  always_comb begin
    bmp_a_d  = bmp_a_q;
    bmp_b_d  = bmp_b_q;
    attr_b_d = attr_b_q;
    vld_b_d  = vld_b_q;
    if (req && !attr_sel) begin
      if (bank_b) bmp_b_d = rdata;
      else        bmp_a_d = rdata;
    end
    if (req && attr_sel && bank_b) begin
      attr_b_d = rdata;
      vld_b_d  = 1'b1;
    end
    if (load && load_second) vld_b_d = 1'b0;
  end

  always_comb begin
    if (load_second) begin
      out_pair.bmp   = bmp_b_q;
      out_pair.attr  = attr_b_q;
      out_pair.valid = vld_b_q;
    end else begin
      out_pair.bmp   = bmp_a_q;
      out_pair.attr  = rdata;
      out_pair.valid = req & attr_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bmp_a_q  <= '0;
      bmp_b_q  <= '0;
      attr_b_q <= '0;
      vld_b_q  <= 1'b0;
    end else begin
      bmp_a_q  <= bmp_a_d;
      bmp_b_q  <= bmp_b_d;
      attr_b_q <= attr_b_d;
      vld_b_q  <= vld_b_d;
    end
  end
endmodule

// File: rtl/pfs_out_stage.sv
module pfs_out_stage
  import pair_fetch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pix_ce,
  input  logic      load,
  input  pair_t     in_pair,
  output logic      pix_out,
  output pix_byte_t attr_out
);
  pix_byte_t sh_q, sh_d;
  pix_byte_t attr_q, attr_d;

  always_comb begin
    sh_d   = sh_q;
    attr_d = attr_q;
    if (load) begin
      sh_d   = in_pair.valid ? in_pair.bmp  : '0;
      attr_d = in_pair.valid ? in_pair.attr : '0;
    end else if (pix_ce) begin
      sh_d = {sh_q[PIX_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      attr_q <= '0;
    end else begin
      sh_q   <= sh_d;
      attr_q <= attr_d;
    end
  end

  assign pix_out  = sh_q[PIX_W-1];
  assign attr_out = attr_q;
endmodule

// File: rtl/pfs_delay.sv
module pfs_delay #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] stage_q;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  stage_q <= '0;
        else if (en) stage_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  stage_q <= '0;
        else if (en) stage_q <= {stage_q[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/pair_fetch_seq.sv
module pair_fetch_seq
  import pair_fetch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_ce,
  input  logic [HC_W-1:0]  hcount,
  input  logic             disp_active,
  input  logic [PIX_W-1:0] mem_rdata,
  output logic             mem_req,
  output logic             mem_attr_sel,
  output logic             addr_inc,
  output logic             shift_load,
  output logic             cpu_contend,
  output logic             pix_out,
  output logic [PIX_W-1:0] attr_out,
  output logic             vid_en_out
);
  logic  rst_n_i;
  logic  bank_b, load_second;
  pair_t stage_pair;

  pfs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  pfs_decode u_dec (
    .hcount      (hcount),
    .pix_ce      (pix_ce),
    .disp_active (disp_active),
    .req         (mem_req),
    .attr_sel    (mem_attr_sel),
    .bank_b      (bank_b),
    .load        (shift_load),
    .load_second (load_second),
    .contend     (cpu_contend)
  );

  pfs_pair_stage u_stage (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .req         (mem_req),
    .attr_sel    (mem_attr_sel),
    .bank_b      (bank_b),
    .load        (shift_load),
    .load_second (load_second),
    .rdata       (mem_rdata),
    .out_pair    (stage_pair)
  );

  pfs_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .pix_ce   (pix_ce),
    .load     (shift_load),
    .in_pair  (stage_pair),
    .pix_out  (pix_out),
    .attr_out (attr_out)
  );

  pfs_delay #(.DEPTH(VID_DLY)) u_vdly (
    .clk   (clk),
    .rst_n (rst_n_i),
    .en    (pix_ce),
    .din   (disp_active),
    .dout  (vid_en_out)
  );

  assign addr_inc = shift_load & stage_pair.valid;
endmodule

// File: rtl/pair_fetch_seq_chk.sv
module pair_fetch_seq_chk
  import pair_fetch_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pix_ce,
  input logic [HC_W-1:0]  hcount,
  input logic             disp_active,
  input logic [PIX_W-1:0] mem_rdata,
  input logic             mem_req,
  input logic             mem_attr_sel,
  input logic             addr_inc,
  input logic             shift_load,
  input logic             cpu_contend,
  input logic [PIX_W-1:0] attr_out
);
  p_req_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!hcount[HC_W-1] && hcount[0] && disp_active && pix_ce));

  p_sel_in_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && hcount[1:0] == 2'b01) |-> !mem_attr_sel);

  p_load_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_load |-> (hcount[1:0] == 2'b11 && !hcount[2] && pix_ce));

  p_attr_same_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_load && mem_req) |=> (attr_out == $past(mem_rdata)));

  p_inc_with_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_inc |-> shift_load);

  p_no_contend_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hcount[HC_W-1] |-> !cpu_contend);
endmodule

bind pair_fetch_seq pair_fetch_seq_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pix_ce       (pix_ce),
  .hcount       (hcount),
  .disp_active  (disp_active),
  .mem_rdata    (mem_rdata),
  .mem_req      (mem_req),
  .mem_attr_sel (mem_attr_sel),
  .addr_inc     (addr_inc),
  .shift_load   (shift_load),
  .cpu_contend  (cpu_contend),
  .attr_out     (attr_out)
);

// File: tb/test_pair_fetch_seq.sv
`timescale 1ns/1ps
module test_pair_fetch_seq;
  logic       clk;
  logic       rst_n;
  logic       pix_ce;
  logic [3:0] hcount;
  logic       disp_active;
  logic [7:0] mem_rdata;
  logic       mem_req, mem_attr_sel, addr_inc, shift_load, cpu_contend;
  logic       pix_out, vid_en_out;
  logic [7:0] attr_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference state
  logic [7:0] m_sh, m_attr, m_bmp_a, m_bmp_b, m_attr_b;
  logic       m_vb;
  logic [3:0] m_dly;

  pair_fetch_seq i_pair_fetch_seq (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .hcount(hcount),
    .disp_active(disp_active), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_attr_sel(mem_attr_sel), .addr_inc(addr_inc), .shift_load(shift_load),
    .cpu_contend(cpu_contend), .pix_out(pix_out), .attr_out(attr_out),
    .vid_en_out(vid_en_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h hc=%0d t=%0t", req, act, exp, hcount, $time);
    end
  endtask

  function automatic logic exp_req(input logic ce, input logic a, input logic [3:0] hc);
    return ce & a & ~hc[3] & hc[0];
  endfunction

  function automatic logic exp_load(input logic ce, input logic [3:0] hc);
    return ce & (hc == 4'd3 || hc == 4'd11);
  endfunction

  // compare all outputs to the reference, then advance the reference by one edge
  task automatic step_check();
    logic rq, ld, vl;
    logic [7:0] nb, na;
    rq = exp_req(pix_ce, disp_active, hcount);
    ld = exp_load(pix_ce, hcount);
    vl = 1'b0; nb = 8'h00; na = 8'h00;
    if (ld && hcount == 4'd3)  begin vl = rq;   nb = m_bmp_a; na = mem_rdata; end
    if (ld && hcount == 4'd11) begin vl = m_vb; nb = m_bmp_b; na = m_attr_b;  end
    check("R2 mem_req", {7'b0, mem_req}, {7'b0, rq});
    check("R3 attr_sel", {7'b0, mem_attr_sel}, {7'b0, hcount[1]});
    check("R4 shift_load", {7'b0, shift_load}, {7'b0, ld});
    check("R7 addr_inc", {7'b0, addr_inc}, {7'b0, ld & vl});
    check("R9 cpu_contend", {7'b0, cpu_contend}, {7'b0, disp_active & ~hcount[3]});
    check("R8 pix_out", {7'b0, pix_out}, {7'b0, m_sh[7]});
    check("R5 R6 attr_out", attr_out, m_attr);
    check("R10 vid_en_out", {7'b0, vid_en_out}, {7'b0, m_dly[3]});
    // advance reference
    if (ld) begin
      m_sh   = vl ? nb : 8'h00;   // R11 zero when pair missing
      m_attr = vl ? na : 8'h00;
      if (hcount == 4'd11) m_vb = 1'b0;
    end else if (pix_ce) begin
      m_sh = {m_sh[6:0], 1'b0};
    end
    if (rq && !hcount[1]) begin
      if (hcount[2]) m_bmp_b = mem_rdata; else m_bmp_a = mem_rdata;
    end
    if (rq && hcount[1] && hcount[2]) begin
      m_attr_b = mem_rdata; m_vb = 1'b1;
    end
    if (pix_ce) m_dly = {m_dly[2:0], disp_active};
  endtask

  // mode: 0 = full rate, stable display; 1 = random stalls; 2 = random mid-window toggles
  task automatic run(input int cycles, input int mode, input logic act_base);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pix_ce) hcount = hcount + 4'd1;
      pix_ce      = (mode == 0) ? 1'b1 : (($urandom % 4) != 0);
      disp_active = (mode == 2) ? (($urandom % 3) != 0) :
                    ((hcount == 4'd0) ? act_base : disp_active);
      mem_rdata   = 8'($urandom);
      #1;
      step_check();
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; pix_ce = 1'b0; hcount = 4'd0; disp_active = 1'b0; mem_rdata = 8'h00;
    m_sh = '0; m_attr = '0; m_bmp_a = '0; m_bmp_b = '0; m_attr_b = '0; m_vb = 1'b0; m_dly = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pix_out reset", {7'b0, pix_out}, 8'h00);
    check("R1 attr_out reset", attr_out, 8'h00);
    check("R1 vid_en_out reset", {7'b0, vid_en_out}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 pix_out after release", {7'b0, pix_out}, 8'h00);
    // directed: one window at full rate with known bytes
    disp_active = 1'b1;
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      pix_ce = 1'b1;
      if (c != 0) hcount = hcount + 4'd1;
      mem_rdata = {hcount, 4'hA} ^ 8'h81;
      #1;
      step_check();
    end
    run(400, 0, 1'b1);   // R5 R6 R8 steady display
    run(300, 0, 1'b0);   // R11 inactive: zero loads
    run(2000, 1, 1'b1);  // stalls incl. on load counts
    run(2000, 2, 1'b1);  // R10 R11 mid-window toggles
    run(1500, 1, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule